// File: doc/BRIEF.md
# PCI Slot Hotplug Register Block

This block keeps the hot-add and hot-remove state of up to 32 PCI slots and shows it to software through a small window of four 32-bit registers. Slot logic reports events on strobes that carry a slot number. A hot-plug event marks the slot present. An unplug event marks the slot as waiting for removal. A coldplug event marks a device found at boot, and it does not notify software. Plug and unplug events raise a one-cycle request toward the general-purpose event status logic.

Software finishes a removal by writing a slot bitmap to the eject register. The block takes the lowest set bit, clears that slot's pending-removal flag and sends a one-cycle eject strobe with the slot index to the slot power logic. The slot's presence is cleared at the same time, unless the slot is marked as holding a device that cannot be hotplugged.

A synchronous device-reset request first ejects every pending slot, one per cycle, lowest slot first. It then rebuilds the enable mask from the non-hotpluggable mask and rebuilds presence from the live occupancy input.

Top module: `pci_slot_hotplug`

## Requirements
- R1: After `rstN` is asserted, all registers hold their reset values: presence is 0, pending removal is 0 and the hotplug-enable mask is all ones. `gpeReq` and `ejectStb` are low.
- R2: A read is a full access: `busValid`=1, `busWrite`=0, `busBe`=4'hF and `busAddr[1:0]`=0. A full read returns, combinationally:
  - word 0 (offset 0x0): presence AND enable;
  - word 1 (offset 0x4): the pending-removal mask;
  - word 2 (offset 0x8): zero;
  - word 3 (offset 0xC): the enable mask.
  
  Any other bus state gives `busRdata`=0.
- R3: A `plugStb` sets presence for `evtSlot`, and `gpeReq` pulses for one cycle after that edge.
- R4: An `unplugStb` sets pending removal for `evtSlot`, and `gpeReq` pulses for one cycle after that edge.
- R5: A `coldStb` sets presence for `evtSlot` and does not raise `gpeReq`.
- R6: A full write to offset 0x8 with nonzero data selects the lowest set data bit. It clears that slot's pending bit. After that edge, it pulses `ejectStb` for exactly one cycle with `ejectSlot` equal to the index.
- R7: An eject clears the slot's presence bit unless `fixedMask` has that bit set.
- R8: The following writes change nothing:
  - writes to offsets 0x0, 0x4 and 0xC;
  - writes whose byte enables are not 4'hF;
  - writes with a misaligned address;
  - an eject write of zero.
- R9: When idle, `resetReq` starts a drain. On each following cycle, the lowest pending slot is ejected as in R6/R7. Once nothing is pending, one cycle sets enable to ~`fixedMask`, sets presence to `occupancy` and returns to idle.
- R10: While a drain runs, slot events, bus writes and further `resetReq` are ignored.
- R11: When an event and an eject write occur in the same cycle, the eject is applied first and the event's bit is set on top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetReq | input | 1 | Synchronous device-reset request (drain, then rebuild) |
| plugStb | input | 1 | Hot-add event for `evtSlot` |
| unplugStb | input | 1 | Hot-remove request for `evtSlot` |
| coldStb | input | 1 | Boot-time presence for `evtSlot` |
| evtSlot | input | 5 | Slot number of the event strobes |
| fixedMask | input | 32 | Slots holding a device that cannot be hotplugged |
| occupancy | input | 32 | Current slot occupancy, sampled at rebuild |
| busValid | input | 1 | Register access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset within the window |
| busBe | input | 4 | Byte enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| gpeReq | output | 1 | One-cycle request to set the hotplug event status bit |
| ejectStb | output | 1 | One-cycle eject pulse |
| ejectSlot | output | 5 | Index of the slot being ejected |

## Verification
The assertions assume the following about the inputs:
- every input is at a known level from the first clock after reset;
- `evtSlot` always names a slot below the slot count;
- `fixedMask` and `occupancy` are sampled only on the edge where they are used.

The stimulus keeps slot numbers in range and changes inputs only between clock edges. Its random phase draws eject data with several set bits, so the lowest-bit choice is tested, and it fires device resets with many slots pending, so multi-cycle drains are covered.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int HP_IDX_W  = 5;
  localparam int HP_REG_W  = 32;
  localparam int HP_ADDR_W = 4;
  localparam int HP_BE_W   = HP_REG_W / 8;

  typedef logic [HP_IDX_W-1:0] slotIdx_t;

  localparam logic [1:0] WORD_UP    = 2'd0;
  localparam logic [1:0] WORD_DOWN  = 2'd1;
  localparam logic [1:0] WORD_EJECT = 2'd2;
  localparam logic [1:0] WORD_RMV   = 2'd3;

  typedef enum logic {ST_RUN, ST_DRAIN} hpState_t;

  typedef struct packed {
    logic     ejectDo;
    slotIdx_t ejectIdx;
    logic     plugDo;
    logic     unplugDo;
    logic     coldDo;
    slotIdx_t evtIdx;
    logic     rebuildDo;
  } hpStrobe_t;
endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resetReq,
  input  logic                 plugStb,
  input  logic                 unplugStb,
  input  logic                 coldStb,
  input  slotIdx_t             evtSlot,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [HP_ADDR_W-1:0] busAddr,
  input  logic [HP_BE_W-1:0]   busBe,
  input  logic [HP_REG_W-1:0]  busWdata,
  input  logic [SLOTS-1:0]     pending,
  output hpStrobe_t            strobe
);
  hpState_t state, nextState;
  logic ejectWrite;
  logic [SLOTS-1:0] wrSlots;

  function automatic slotIdx_t lowestIdx(input logic [SLOTS-1:0] v);
    slotIdx_t r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = slotIdx_t'(i);
    end
    return r;
  endfunction

  assign wrSlots    = busWdata[SLOTS-1:0];
  assign ejectWrite = busValid && busWrite && (busBe == {HP_BE_W{1'b1}}) &&
                      (busAddr[1:0] == 2'b00) && (busAddr[3:2] == WORD_EJECT);

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_RUN: begin
        if (resetReq) begin
          nextState = ST_DRAIN;
        end else begin
          strobe.ejectDo  = ejectWrite && (|wrSlots);
          strobe.ejectIdx = lowestIdx(wrSlots);
          strobe.plugDo   = plugStb;
          strobe.unplugDo = unplugStb;
          strobe.coldDo   = coldStb;
          strobe.evtIdx   = evtSlot;
        end
      end
      default: begin
        if (|pending) begin
          strobe.ejectDo  = 1'b1;
          strobe.ejectIdx = lowestIdx(pending);
        end else begin
          strobe.rebuildDo = 1'b1;
          nextState        = ST_RUN;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  logic [SLOTS-1:0] belowMask;
  assign belowMask = (SLOTS'(1) << strobe.ejectIdx) - SLOTS'(1);

  AST_EJECT_LOWEST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && strobe.ejectDo) |-> (wrSlots[strobe.ejectIdx] && ((wrSlots & belowMask) == '0))); // R6
  AST_DRAIN_LOWEST_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && (|pending)) |-> (strobe.ejectDo && pending[strobe.ejectIdx] && ((pending & belowMask) == '0))); // R9
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hp_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hpStrobe_t            strobe,
  input  logic [SLOTS-1:0]     fixedMask,
  input  logic [SLOTS-1:0]     occupancy,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [HP_ADDR_W-1:0] busAddr,
  input  logic [HP_BE_W-1:0]   busBe,
  output logic [HP_REG_W-1:0]  busRdata,
  output logic [SLOTS-1:0]     pending,
  output logic                 gpeReq,
  output logic                 ejectStb,
  output slotIdx_t             ejectSlot
);
  logic [SLOTS-1:0] presentQ, pendingQ, enableQ;
  logic [SLOTS-1:0] presNext, pendNext, enNext;
  logic fullRead;

  always_comb begin
    presNext = presentQ;
    pendNext = pendingQ;
    enNext   = enableQ;
    if (strobe.ejectDo) begin
      pendNext[strobe.ejectIdx] = 1'b0;
      if (!fixedMask[strobe.ejectIdx]) presNext[strobe.ejectIdx] = 1'b0;
    end
    if (strobe.rebuildDo) begin
      enNext   = ~fixedMask;
      presNext = occupancy;
    end
    if (strobe.plugDo)   presNext[strobe.evtIdx] = 1'b1;
    if (strobe.coldDo)   presNext[strobe.evtIdx] = 1'b1;
    if (strobe.unplugDo) pendNext[strobe.evtIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presentQ  <= '0;
      pendingQ  <= '0;
      enableQ   <= '1;
      gpeReq    <= 1'b0;
      ejectStb  <= 1'b0;
      ejectSlot <= '0;
    end else begin
      presentQ  <= presNext;
      pendingQ  <= pendNext;
      enableQ   <= enNext;
      gpeReq    <= strobe.plugDo || strobe.unplugDo;
      ejectStb  <= strobe.ejectDo;
      ejectSlot <= strobe.ejectDo ? strobe.ejectIdx : ejectSlot;
    end
  end

  assign pending  = pendingQ;
  assign fullRead = busValid && !busWrite && (busBe == {HP_BE_W{1'b1}}) && (busAddr[1:0] == 2'b00);

  always_comb begin
    busRdata = '0;
    if (fullRead) begin
      case (busAddr[3:2])
        WORD_UP:   busRdata = HP_REG_W'(presentQ & enableQ);
        WORD_DOWN: busRdata = HP_REG_W'(pendingQ);
        WORD_RMV:  busRdata = HP_REG_W'(enableQ);
        default:   busRdata = '0;
      endcase
    end
  end

  AST_EJECT_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ejectDo && !(strobe.unplugDo && strobe.evtIdx == strobe.ejectIdx))
      |=> !pendingQ[$past(strobe.ejectIdx)]); // R6
  AST_FIXED_KEEPS_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ejectDo && !strobe.rebuildDo && presentQ[strobe.ejectIdx] && fixedMask[strobe.ejectIdx])
      |=> presentQ[$past(strobe.ejectIdx)]); // R7
  AST_COLD_NO_GPE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.coldDo && !strobe.plugDo && !strobe.unplugDo) |=> !gpeReq); // R5
  AST_REBUILD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rebuildDo && !strobe.unplugDo) |=> (enableQ == ~$past(fixedMask) && pendingQ == '0)); // R9
endmodule

// File: rtl/pci_slot_hotplug.sv
module pci_slot_hotplug
  import hp_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resetReq,
  input  logic                 plugStb,
  input  logic                 unplugStb,
  input  logic                 coldStb,
  input  logic [HP_IDX_W-1:0]  evtSlot,
  input  logic [SLOTS-1:0]     fixedMask,
  input  logic [SLOTS-1:0]     occupancy,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [HP_ADDR_W-1:0] busAddr,
  input  logic [HP_BE_W-1:0]   busBe,
  input  logic [HP_REG_W-1:0]  busWdata,
  output logic [HP_REG_W-1:0]  busRdata,
  output logic                 gpeReq,
  output logic                 ejectStb,
  output logic [HP_IDX_W-1:0]  ejectSlot
);
  hpStrobe_t strobe;
  logic [SLOTS-1:0] pending;

  hp_ctrl #(.SLOTS(SLOTS)) i_ctrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq),
    .plugStb(plugStb), .unplugStb(unplugStb), .coldStb(coldStb), .evtSlot(evtSlot),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .pending(pending), .strobe(strobe)
  );

  hp_regs #(.SLOTS(SLOTS)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fixedMask(fixedMask), .occupancy(occupancy),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busBe(busBe),
    .busRdata(busRdata), .pending(pending),
    .gpeReq(gpeReq), .ejectStb(ejectStb), .ejectSlot(ejectSlot)
  );
endmodule

// File: tb/test_pci_slot_hotplug.sv
module test_pci_slot_hotplug;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, resetReq, plugStb, unplugStb, coldStb;
  logic [4:0]  evtSlot;
  logic [31:0] fixedMask, occupancy;
  logic        busValid, busWrite;
  logic [3:0]  busAddr, busBe;
  logic [31:0] busWdata, busRdata;
  logic        gpeReq, ejectStb;
  logic [4:0]  ejectSlot;

  pci_slot_hotplug i_pci_slot_hotplug (
    .clk(clk), .rstN(rstN), .resetReq(resetReq),
    .plugStb(plugStb), .unplugStb(unplugStb), .coldStb(coldStb), .evtSlot(evtSlot),
    .fixedMask(fixedMask), .occupancy(occupancy),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata),
    .gpeReq(gpeReq), .ejectStb(ejectStb), .ejectSlot(ejectSlot)
  );

  int    nCmp = 0, nBad = 0;
  string tag = "R1";
  bit    finished = 0;

  // behavioural reference state
  logic [31:0] mPres, mPend, mEn;
  bit mDrain, mGpe, mEj;
  int mEjSlot;

  function automatic int lowest(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPres = 0; mPend = 0; mEn = '1; mDrain = 0; mGpe = 0; mEj = 0; mEjSlot = 0;
    end else begin
      mGpe = 0; mEj = 0;
      if (mDrain) begin
        if (mPend != 0) begin
          mEjSlot = lowest(mPend); mEj = 1;
          mPend[mEjSlot] = 1'b0;
          if (!fixedMask[mEjSlot]) mPres[mEjSlot] = 1'b0;
        end else begin
          mEn = ~fixedMask; mPres = occupancy; mDrain = 0;
        end
      end else if (resetReq) begin
        mDrain = 1;
      end else begin
        if (busValid && busWrite && busBe == 4'hF && busAddr == 4'h8 && busWdata != 0) begin
          mEjSlot = lowest(busWdata); mEj = 1;
          mPend[mEjSlot] = 1'b0;
          if (!fixedMask[mEjSlot]) mPres[mEjSlot] = 1'b0;
        end
        if (plugStb)   begin mPres[evtSlot] = 1'b1; mGpe = 1; end
        if (coldStb)   mPres[evtSlot] = 1'b1;
        if (unplugStb) begin mPend[evtSlot] = 1'b1; mGpe = 1; end
      end
    end
  end

  function automatic logic [31:0] expRead();
    if (busValid && !busWrite && busBe == 4'hF && busAddr[1:0] == 2'b00) begin
      case (busAddr[3:2])
        2'd0: return mPres & mEn;
        2'd1: return mPend;
        2'd3: return mEn;
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    cmp("gpeReq", {31'b0, gpeReq}, {31'b0, mGpe});
    cmp("ejectStb", {31'b0, ejectStb}, {31'b0, mEj});
    if (mEj) cmp("ejectSlot", {27'b0, ejectSlot}, mEjSlot);
    cmp("busRdata", busRdata, expRead());
  endtask

  task automatic clr();
    resetReq = 0; plugStb = 0; unplugStb = 0; coldStb = 0; evtSlot = 0;
    busValid = 0; busWrite = 0; busAddr = 0; busBe = 4'hF; busWdata = 0;
  endtask

  task automatic rd(logic [3:0] a);
    clr(); busValid = 1; busAddr = a; step();
  endtask

  task automatic readAll();
    rd(4'h0); rd(4'h4); rd(4'h8); rd(4'hC); clr();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d; busBe = be;
    step(); clr();
  endtask

  task automatic ev(int kind, int slot);
    clr(); evtSlot = 5'(slot);
    if (kind == 0) plugStb = 1; else if (kind == 1) unplugStb = 1; else coldStb = 1;
    step(); clr();
  endtask

  initial begin
    rstN = 0; fixedMask = 0; occupancy = 0; clr();
    repeat (3) step();
    rstN = 1;
    tag = "R1"; readAll();
    tag = "R2"; rd(4'h1); rd(4'h2); clr(); busValid = 1; busAddr = 4'h4; busBe = 4'h7; step(); clr();
    tag = "R5"; ev(2, 3); readAll();
    tag = "R3"; ev(0, 7); ev(0, 10); readAll();
    tag = "R4"; ev(1, 3); ev(1, 10); ev(1, 31); readAll();
    tag = "R8";
    wr(4'h0, 32'hFFFF_FFFF, 4'hF); wr(4'h4, 32'hFFFF_FFFF, 4'hF); wr(4'hC, 32'h0, 4'hF);
    wr(4'h8, 32'h0, 4'hF); wr(4'h8, 32'h8, 4'h3); wr(4'h9, 32'h8, 4'hF); readAll();
    tag = "R6"; wr(4'h8, 32'h0000_0408, 4'hF); readAll();
    tag = "R7"; fixedMask = 32'h0000_0400; wr(4'h8, 32'h0000_0400, 4'hF); readAll();
    tag = "R6"; wr(4'h8, 32'h8000_0000, 4'hF); readAll();
    tag = "R11"; clr(); unplugStb = 1; evtSlot = 5; wr(4'h8, 32'h20, 4'hF); readAll();
    clr(); plugStb = 1; evtSlot = 10; fixedMask = 0; wr(4'h8, 32'h400, 4'hF); readAll();
    tag = "R9"; ev(1, 1); ev(1, 4); ev(1, 20); ev(0, 4);
    fixedMask = 32'h0000_0010; occupancy = 32'h00F0_0F0F;
    clr(); resetReq = 1; step();
    tag = "R10";
    while (mDrain) begin
      clr(); plugStb = 1; unplugStb = 1; evtSlot = 9; resetReq = 1;
      busValid = 1; busWrite = 1; busAddr = 4'h8; busWdata = 32'h200; step();
    end
    tag = "R9"; readAll();

    tag = "R2/R3/R4/R5/R6/R7/R9/R11";
    for (int n = 0; n < 4000; n++) begin
      clr();
      plugStb   = ($urandom % 6) == 0;
      unplugStb = ($urandom % 5) == 0;
      coldStb   = ($urandom % 9) == 0;
      evtSlot   = 5'($urandom);
      resetReq  = ($urandom % 150) == 0;
      if (($urandom % 60) == 0) fixedMask = $urandom & $urandom;
      if (($urandom % 40) == 0) occupancy = $urandom;
      busValid = ($urandom % 3) != 0;
      busWrite = ($urandom % 3) == 0;
      busAddr  = (($urandom % 8) == 0) ? 4'($urandom) : {2'($urandom), 2'b00};
      busBe    = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      busWdata = $urandom & $urandom & $urandom;
      step();
    end
    clr(); step();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule